// File: doc/BRIEF.md
# I2C Interrupt and Wakeup Controller

This block sits beside an I2C protocol engine and turns the engine's one-cycle event reports into sticky status flags and three interrupt lines. The flags fall into three groups: transfer events, buffer status and error conditions. Each group reaches its interrupt line only through the enable bits assigned to it. The event line and the error line are ORed into a single global line. Software clears each flag with a write strobe.

The block also handles wakeup from a low-power halt state in slave mode. While halted, the only report it acts on is a slave address match. That match raises a dedicated wake flag and nothing else. The acknowledge for that address is withheld, so the master has to resend it. Unless stretching is turned off, the clock line is held low from the acknowledge slot until software clears the wake flag. Entering halt produces a one-cycle pulse that resets the engine's slave communication state. The configuration inputs are left untouched.

A master-mode status bit is set when the engine starts a master transfer. Losing arbitration clears it, which returns the block to slave mode.

Top module: `i2c_irq_wake`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every flag, all three interrupt outputs, `sclHold`, `masterMode` and `commReset` read 0.
- R2: A flag set at a clock edge stays set until a clock edge where its clear strobe is high. If the set pulse and the clear strobe for the same bit arrive in the same cycle, the flag ends up set.
- R3: Event bits are: bit 0 start sent, bit 1 address matched, bit 2 ten-bit header sent, bit 3 stop seen, bit 4 byte finished. Any set event bit, or the wake flag, drives `evtIrq` only when `evtEnable` is 1.
- R4: Buffer bits are: bit 0 receive full, bit 1 transmit empty. A set buffer bit drives `evtIrq` only when both `evtEnable` and `bufEnable` are 1.
- R5: Error bits are: bit 0 bus error, bit 1 arbitration lost, bit 2 acknowledge failure, bit 3 overrun/underrun. Any set error bit drives `errIrq` only when `errEnable` is 1.
- R6: `globalIrq` is the OR of the event and error lines. All three interrupt outputs are registered: they follow a flag or enable change at the next clock edge after it.
- R7: While `haltMode` is 1, a pulse on event bit 1 (address matched) sets `wakeFlag`. Every other event, buffer or error set pulse is ignored, and event bit 1 itself is not set.
- R8: `ackBlock` is 1 whenever `haltMode` is 1 or `wakeFlag` is set. Otherwise it is 0.
- R9: With `stretchOff` at 0, an `ackSlot` pulse while `wakeFlag` is set raises `sclHold` at the next edge. It stays high until the edge where `wakeClr` clears the wake flag. With `stretchOff` at 1, `sclHold` never rises.
- R10: `commReset` pulses high for exactly one cycle, at the edge after `haltMode` rises.
- R11: `masterGo` sets `masterMode`. An arbitration-lost pulse (error bit 1) accepted outside halt clears `masterMode` and takes priority over `masterGo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtEnable | input | 1 | Event interrupt enable |
| bufEnable | input | 1 | Buffer interrupt enable (needs evtEnable too) |
| errEnable | input | 1 | Error interrupt enable |
| stretchOff | input | 1 | 1 disables clock holding during wakeup |
| haltMode | input | 1 | Device is in the low-power halt state |
| evtSet | input | 5 | Event set pulses from the protocol engine |
| bufSet | input | 2 | Buffer set pulses |
| errSet | input | 4 | Error set pulses |
| evtClr | input | 5 | Event clear strobes from software |
| bufClr | input | 2 | Buffer clear strobes |
| errClr | input | 4 | Error clear strobes |
| wakeClr | input | 1 | Wake flag clear strobe |
| ackSlot | input | 1 | Pulse marking the end of an acknowledge slot |
| masterGo | input | 1 | Engine has begun a master transfer |
| evtFlags | output | 5 | Event flag state |
| bufFlags | output | 2 | Buffer flag state |
| errFlags | output | 4 | Error flag state |
| wakeFlag | output | 1 | Wake-from-halt flag |
| evtIrq | output | 1 | Event interrupt |
| errIrq | output | 1 | Error interrupt |
| globalIrq | output | 1 | Combined interrupt |
| ackBlock | output | 1 | Engine must not acknowledge |
| sclHold | output | 1 | Engine must hold the clock line low |
| masterMode | output | 1 | Block is acting as master |
| commReset | output | 1 | One-cycle slave state reset on halt entry |

## Verification
The assertions assume that set pulses and clear strobes are sampled only at clock edges, with no meaning attached to their width. They also assume that `haltMode` does not toggle in the same cycle as the address-match pulse it should govern. The stimulus changes every input on the falling edge and holds it for whole cycles. It raises or drops `haltMode` only in cycles with no set pulses. It drives `ackSlot` only after the wake flag is visibly set, so the hold logic always sees a settled flag.

// File: rtl/i2cirq_pkg.sv
package i2cirq_pkg;
  localparam int EVT_N = 5;
  localparam int BUF_N = 2;
  localparam int ERR_N = 4;
  // bit positions whose meaning the control logic depends on
  localparam int ADDR_BIT = 1;
  localparam int ARB_BIT  = 1;

  typedef struct packed {
    logic [EVT_N-1:0] evtSet;
    logic [BUF_N-1:0] bufSet;
    logic [ERR_N-1:0] errSet;
    logic             wakeSet;
  } flagStrobe_t;
endpackage

// File: rtl/i2cirq_sticky.sv
module i2cirq_sticky #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setIn,
  input  logic [WIDTH-1:0] clrIn,
  output logic [WIDTH-1:0] flagQ
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)          flagQ[i] <= 1'b0;
      else if (setIn[i])  flagQ[i] <= 1'b1;   // set has priority over clear
      else if (clrIn[i])  flagQ[i] <= 1'b0;
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(flagQ) & ~$past(clrIn) & ~flagQ) == '0));
endmodule

// File: rtl/i2cirq_ctrl.sv
module i2cirq_ctrl
  import i2cirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltMode,
  input  logic             stretchOff,
  input  logic [EVT_N-1:0] evtSetIn,
  input  logic [BUF_N-1:0] bufSetIn,
  input  logic [ERR_N-1:0] errSetIn,
  input  logic             ackSlot,
  input  logic             wakeClr,
  input  logic             wakeFlag,
  input  logic             masterGo,
  output flagStrobe_t      strobe,
  output logic             sclHold,
  output logic             masterMode,
  output logic             commReset
);
  logic haltQ;

  // While halted, only the address match is honoured, and it is routed to the wake flag.
  always_comb begin
    strobe.evtSet  = haltMode ? '0 : evtSetIn;
    strobe.bufSet  = haltMode ? '0 : bufSetIn;
    strobe.errSet  = haltMode ? '0 : errSetIn;
    strobe.wakeSet = haltMode & evtSetIn[ADDR_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltQ     <= 1'b0;
      commReset <= 1'b0;
    end else begin
      haltQ     <= haltMode;
      commReset <= haltMode & ~haltQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  sclHold <= 1'b0;
    else if (wakeClr && !strobe.wakeSet)        sclHold <= 1'b0;
    else if (ackSlot && wakeFlag && !stretchOff) sclHold <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        masterMode <= 1'b0;
    else if (strobe.errSet[ARB_BIT])  masterMode <= 1'b0;
    else if (masterGo)                masterMode <= 1'b1;
  end

  // R9
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclHold) |-> $past(wakeFlag && !stretchOff && ackSlot));
  // R10
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commReset |=> !commReset);
  // R11
  arb_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errSetIn[ARB_BIT]) && !$past(haltMode) && $past(rstN)) |-> !masterMode);
endmodule

// File: rtl/i2cirq_flags.sv
module i2cirq_flags
  import i2cirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobe_t      strobe,
  input  logic [EVT_N-1:0] evtClr,
  input  logic [BUF_N-1:0] bufClr,
  input  logic [ERR_N-1:0] errClr,
  input  logic             wakeClr,
  input  logic             evtEnable,
  input  logic             bufEnable,
  input  logic             errEnable,
  output logic [EVT_N-1:0] evtFlags,
  output logic [BUF_N-1:0] bufFlags,
  output logic [ERR_N-1:0] errFlags,
  output logic             wakeFlag,
  output logic             evtIrq,
  output logic             errIrq,
  output logic             globalIrq
);
  logic evtNext, errNext;

  i2cirq_sticky #(.WIDTH(EVT_N)) u_evt (.clk(clk), .rstN(rstN), .setIn(strobe.evtSet),
    .clrIn(evtClr), .flagQ(evtFlags));
  i2cirq_sticky #(.WIDTH(BUF_N)) u_buf (.clk(clk), .rstN(rstN), .setIn(strobe.bufSet),
    .clrIn(bufClr), .flagQ(bufFlags));
  i2cirq_sticky #(.WIDTH(ERR_N)) u_err (.clk(clk), .rstN(rstN), .setIn(strobe.errSet),
    .clrIn(errClr), .flagQ(errFlags));
  i2cirq_sticky #(.WIDTH(1)) u_wake (.clk(clk), .rstN(rstN), .setIn(strobe.wakeSet),
    .clrIn(wakeClr), .flagQ(wakeFlag));

  always_comb begin
    evtNext = evtEnable & ((|evtFlags) | wakeFlag | (bufEnable & (|bufFlags)));
    errNext = errEnable & (|errFlags);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtIrq    <= 1'b0;
      errIrq    <= 1'b0;
      globalIrq <= 1'b0;
    end else begin
      evtIrq    <= evtNext;
      errIrq    <= errNext;
      globalIrq <= evtNext | errNext;
    end
  end

  // R5
  err_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> $past(errEnable));
  // R4
  buf_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIrq && $past(evtFlags) == '0 && !$past(wakeFlag)) |-> $past(evtEnable && bufEnable));
  // R6
  global_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIrq || errIrq) |-> globalIrq);
endmodule

// File: rtl/i2c_irq_wake.sv
module i2c_irq_wake
  import i2cirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtEnable,
  input  logic             bufEnable,
  input  logic             errEnable,
  input  logic             stretchOff,
  input  logic             haltMode,
  input  logic [EVT_N-1:0] evtSet,
  input  logic [BUF_N-1:0] bufSet,
  input  logic [ERR_N-1:0] errSet,
  input  logic [EVT_N-1:0] evtClr,
  input  logic [BUF_N-1:0] bufClr,
  input  logic [ERR_N-1:0] errClr,
  input  logic             wakeClr,
  input  logic             ackSlot,
  input  logic             masterGo,
  output logic [EVT_N-1:0] evtFlags,
  output logic [BUF_N-1:0] bufFlags,
  output logic [ERR_N-1:0] errFlags,
  output logic             wakeFlag,
  output logic             evtIrq,
  output logic             errIrq,
  output logic             globalIrq,
  output logic             ackBlock,
  output logic             sclHold,
  output logic             masterMode,
  output logic             commReset
);
  flagStrobe_t strobe;

  i2cirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .haltMode(haltMode), .stretchOff(stretchOff),
    .evtSetIn(evtSet), .bufSetIn(bufSet), .errSetIn(errSet),
    .ackSlot(ackSlot), .wakeClr(wakeClr), .wakeFlag(wakeFlag), .masterGo(masterGo),
    .strobe(strobe), .sclHold(sclHold), .masterMode(masterMode), .commReset(commReset)
  );

  i2cirq_flags u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evtClr(evtClr), .bufClr(bufClr), .errClr(errClr), .wakeClr(wakeClr),
    .evtEnable(evtEnable), .bufEnable(bufEnable), .errEnable(errEnable),
    .evtFlags(evtFlags), .bufFlags(bufFlags), .errFlags(errFlags), .wakeFlag(wakeFlag),
    .evtIrq(evtIrq), .errIrq(errIrq), .globalIrq(globalIrq)
  );

  assign ackBlock = haltMode | wakeFlag;

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(haltMode) && $past(rstN)) |->
      (((evtFlags & ~$past(evtFlags)) == '0) && ((errFlags & ~$past(errFlags)) == '0)
       && ((bufFlags & ~$past(bufFlags)) == '0)));
  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeFlag |-> ackBlock);
endmodule

// File: tb/sim_i2c_irq_wake.sv
module sim_i2c_irq_wake;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtEnable = 0, bufEnable = 0, errEnable = 0, stretchOff = 0, haltMode = 0;
  logic [4:0] evtSet = '0, evtClr = '0;
  logic [1:0] bufSet = '0, bufClr = '0;
  logic [3:0] errSet = '0, errClr = '0;
  logic wakeClr = 0, ackSlot = 0, masterGo = 0;
  logic [4:0] evtFlags;
  logic [1:0] bufFlags;
  logic [3:0] errFlags;
  logic wakeFlag, evtIrq, errIrq, globalIrq, ackBlock, sclHold, masterMode, commReset;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_irq_wake u0 (.*);

  // {evtEn, bufEn, errEn, evt[4:0], buf[1:0], err[3:0], expEvtIrq, expErrIrq}
  localparam logic [15:0] VEC [10] = '{
    {3'b100, 5'b00001, 2'b00, 4'b0000, 2'b10},
    {3'b011, 5'b00001, 2'b00, 4'b0000, 2'b00},
    {3'b101, 5'b00000, 2'b01, 4'b0000, 2'b00},
    {3'b110, 5'b00000, 2'b10, 4'b0000, 2'b10},
    {3'b010, 5'b00000, 2'b11, 4'b0000, 2'b00},
    {3'b001, 5'b00000, 2'b00, 4'b0100, 2'b01},
    {3'b110, 5'b00000, 2'b00, 4'b1000, 2'b00},
    {3'b111, 5'b10000, 2'b00, 4'b0001, 2'b11},
    {3'b000, 5'b11111, 2'b11, 4'b1111, 2'b00},
    {3'b100, 5'b00100, 2'b00, 4'b0000, 2'b10}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    evtClr = '1; bufClr = '1; errClr = '1; wakeClr = 1;
    tick();
    evtClr = '0; bufClr = '0; errClr = '0; wakeClr = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) tick();
    check("R1 reset state", {evtFlags, bufFlags, errFlags, wakeFlag, evtIrq, errIrq, globalIrq},
          16'h0);
    rstN = 1;
    tick();
    check("R1 after release", {sclHold, masterMode, commReset, globalIrq}, 16'h0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      evtClr = '1; bufClr = '1; errClr = '1;
      {evtEnable, bufEnable, errEnable} = VEC[i][15:13];
      tick();
      evtClr = '0; bufClr = '0; errClr = '0;
      evtSet = VEC[i][12:8]; bufSet = VEC[i][7:6]; errSet = VEC[i][5:2];
      tick();
      evtSet = '0; bufSet = '0; errSet = '0;
      tick();
      check("R3/R4/R5 irq lines", {evtIrq, errIrq}, VEC[i][1:0]);
      check("R6 global line", globalIrq, VEC[i][1] | VEC[i][0]);
      check("R2 flag capture", {evtFlags, bufFlags, errFlags}, VEC[i][12:2]);
    end

    // R2 and R6: sticky, latency, set beats clear
    clearAll();
    evtEnable = 1; bufEnable = 0; errEnable = 0;
    evtSet = 5'b00001;
    tick();
    evtSet = '0;
    check("R6 irq not yet", evtIrq, 0);
    tick();
    check("R6 irq one cycle later", evtIrq, 1);
    tick(); tick();
    check("R2 flag sticky", evtFlags, 5'b00001);
    evtSet = 5'b00001; evtClr = 5'b00001;
    tick();
    evtSet = '0;
    check("R2 set wins", evtFlags, 5'b00001);
    tick();
    evtClr = '0;
    check("R2 clear", evtFlags, 5'b00000);
    tick();
    check("R6 irq drops", evtIrq, 0);

    // R6 enable latency
    errEnable = 0; errSet = 4'b0100;
    tick();
    errSet = '0;
    tick();
    check("R5 gated off", errIrq, 0);
    errEnable = 1;
    tick();
    check("R6 enable change", {errIrq, globalIrq}, 2'b11);
    clearAll();

    // halt entry: R10 R8 R7
    evtEnable = 1; bufEnable = 1; errEnable = 1; stretchOff = 0;
    haltMode = 1;
    tick();
    check("R10 reset pulse", commReset, 1);
    check("R8 ack withheld in halt", ackBlock, 1);
    tick();
    check("R10 single cycle", commReset, 0);
    evtSet = '1; bufSet = '1; errSet = '1;
    tick();
    evtSet = '0; bufSet = '0; errSet = '0;
    check("R7 only wake flag", {evtFlags, bufFlags, errFlags, wakeFlag}, 12'h001);
    tick();
    check("R3 wake raises event irq", {evtIrq, errIrq}, 2'b10);

    // R9 hold
    ackSlot = 1;
    tick();
    ackSlot = 0;
    check("R9 hold raised", sclHold, 1);
    tick(); tick();
    check("R9 hold kept", sclHold, 1);
    haltMode = 0;
    tick();
    check("R8 ack still withheld by wake flag", ackBlock, 1);
    wakeClr = 1;
    tick();
    wakeClr = 0;
    check("R9 hold released", {sclHold, wakeFlag}, 2'b00);
    check("R8 ack allowed", ackBlock, 0);

    // R9 with stretch disabled, R3 gating of wake
    evtEnable = 0; stretchOff = 1; haltMode = 1;
    tick();
    evtSet = 5'b00010;
    tick();
    evtSet = '0;
    check("R7 wake set", wakeFlag, 1);
    ackSlot = 1;
    tick();
    ackSlot = 0;
    check("R9 no hold when off", sclHold, 0);
    check("R3 wake gated", evtIrq, 0);
    clearAll();
    haltMode = 0; stretchOff = 0;
    tick();

    // R11 master mode
    masterGo = 1;
    tick();
    masterGo = 0;
    check("R11 master set", masterMode, 1);
    errSet = 4'b0010; masterGo = 1;
    tick();
    errSet = '0; masterGo = 0;
    check("R11 arb lost clears", {masterMode, errFlags}, 5'b00010);

    finish();
  end
endmodule